// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Controller

This block generates a parameterised number of pulse-width-modulated outputs from one system clock, under control of a small memory-mapped register bus. Two clock sources arrive as single-cycle tick enables: a fast bus tick and a slower oscillator tick. Channels are grouped in pairs. Each pair picks one of the two sources and divides it by a power of two. Each channel then divides that pair tick again by a linear factor. The result drives a 16-bit period counter, and a 16-bit active length is compared against it. Nine and sixteen channels are the configurations in use.

Software programs a channel by writing its pair clock word, its control word (linear prescaler and active level) and its period word (last count and active length). It then sets the channel's gate bit and run bit. Every period opens with the active phase, and the inactive phase fills the rest. New period, active-length or divider values are used from the very next cycle. A period already under way is not allowed to finish first. The register bus is a plain strobe interface with no back-pressure: a write lands at the clock edge that samples the strobe, and read data appears one cycle after the read strobe.

Top module: `pwm_array`

## Requirements
- R1: After reset every register reads zero. Every output sits at the inactive level, which is high because the active-level bit resets to 0.
- R2: Registers read back their implemented fields as last written. Byte offsets: pair clock word at 0x20 + 4*(ch/2), gate word at 0x40, run word at 0x80, control word at 0x100 + 0x20*ch, period word at 0x104 + 0x20*ch. The gate and run words hold one bit per channel, at the bit position equal to the channel number.
- R3: A read of any unmapped address returns zero. Read data is valid in the cycle after the read strobe.
- R4: In the pair clock word, bit 7 set selects the bus tick and bit 7 clear selects the oscillator tick. Bits 3:0 give M, and the selected tick is divided by 2^M. Any M above 8 acts as 8. Both channels of a pair use the same word.
- R5: Control word bits 7:0 give K, and the pair tick is further divided by K+1.
- R6: Control word bit 8 gives the active level: 1 is active-high and 0 is active-low.
- R7: Period word bits 31:16 give P and bits 15:0 give A. The output repeats every P+1 prescaled ticks and is active for the first A of them.
- R8: If A is 0, the output stays constantly inactive. If A is greater than P, it stays constantly active.
- R9: While a channel's gate bit or run bit is clear, its output is held at the inactive level.
- R10: When a channel starts running, its counters restart from zero. If A is nonzero, the output is active in the first cycle after the enabling write.
- R11: A period or prescaler write to a running channel takes effect at once. A count at or beyond the new limit wraps to zero on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | Fast source tick enable |
| osc_tick | input | 1 | Oscillator source tick enable |
| reg_addr | input | AW | Byte address of register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
A write takes effect at the edge that samples the strobe. Read data is due one cycle after the read strobe, so the bench samples it at the following falling edge. Outputs follow the counters with no added register. The bench therefore checks the restart case at the first falling edge after the enabling write, and checks the immediate-write case within a few cycles of the write. Periods and active lengths are measured as intervals between output transitions, so the free-running phase of the dividers never shifts a result. These intervals are compared with (P+1) and A times the tick spacing, the factor 2^M and the factor K+1.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DW          = 32;
  localparam int CLK_BASE    = 'h020;
  localparam int GATE_OFS    = 'h040;
  localparam int RUN_OFS     = 'h080;
  localparam int CHAN_BASE   = 'h100;
  localparam int CHAN_STRIDE = 'h020;
  localparam int PERIOD_OFS  = 4;
  localparam int EXP_MAX     = 8;

  typedef struct packed {
    logic       src_bus;
    logic [3:0] div_exp;
  } pair_cfg_t;

  typedef struct packed {
    logic       act_high;
    logic [7:0] pre;
  } chan_ctl_t;

  typedef struct packed {
    logic [15:0] last;
    logic [15:0] act;
  } chan_per_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH = 9,
  parameter int AW  = 12,
  localparam int NPAIR = (NCH + 1) / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic                   wr_en,
  input  logic                   rd_en,
  output logic [DW-1:0]          rdata,
  output pair_cfg_t [NPAIR-1:0]  pair_cfg,
  output chan_ctl_t [NCH-1:0]    ctl,
  output chan_per_t [NCH-1:0]    per,
  output logic [NCH-1:0]         gate,
  output logic [NCH-1:0]         run_en
);
  logic [DW-1:0] rd_mux;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pair_cfg[p] <= '0;
      else if (wr_en && addr == AW'(CLK_BASE + 4 * p))
        pair_cfg[p] <= '{src_bus: wdata[7], div_exp: wdata[3:0]};
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl[c] <= '0;
        per[c] <= '0;
      end else if (wr_en) begin
        if (addr == AW'(CHAN_BASE + CHAN_STRIDE * c))
          ctl[c] <= '{act_high: wdata[8], pre: wdata[7:0]};
        if (addr == AW'(CHAN_BASE + CHAN_STRIDE * c + PERIOD_OFS))
          per[c] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate   <= '0;
      run_en <= '0;
    end else if (wr_en) begin
      if (addr == AW'(GATE_OFS)) gate   <= wdata[NCH-1:0];
      if (addr == AW'(RUN_OFS))  run_en <= wdata[NCH-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPAIR; p++)
      if (addr == AW'(CLK_BASE + 4 * p))
        rd_mux = {24'b0, pair_cfg[p].src_bus, 3'b0, pair_cfg[p].div_exp};
    if (addr == AW'(GATE_OFS)) rd_mux = DW'(gate);
    if (addr == AW'(RUN_OFS))  rd_mux = DW'(run_en);
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(CHAN_BASE + CHAN_STRIDE * c))
        rd_mux = {23'b0, ctl[c].act_high, ctl[c].pre};
      if (addr == AW'(CHAN_BASE + CHAN_STRIDE * c + PERIOD_OFS))
        rd_mux = per[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm_pair_div.sv
module pwm_pair_div
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_tick,
  input  logic      osc_tick,
  input  pair_cfg_t cfg,
  output logic      div_tick
);
  localparam int CW = EXP_MAX;

  logic          sel_tick;
  logic [3:0]    exp_eff;
  logic [CW:0]   lim;
  logic [CW-1:0] cnt;

  assign sel_tick = cfg.src_bus ? bus_tick : osc_tick;
  assign exp_eff  = (cfg.div_exp > 4'(EXP_MAX)) ? 4'(EXP_MAX) : cfg.div_exp;
  assign lim      = ((CW+1)'(1) << exp_eff) - (CW+1)'(1);
  assign div_tick = sel_tick && (cnt >= lim[CW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (sel_tick) cnt <= div_tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      div_tick,
  input  logic      gate,
  input  logic      run_en,
  input  chan_ctl_t ctl,
  input  chan_per_t per,
  output logic      pwm_o
);
  logic        live;
  logic        pre_fire;
  logic        in_act;
  logic [7:0]  pre_cnt;
  logic [15:0] per_cnt;

  assign live     = gate && run_en;
  assign pre_fire = div_tick && (pre_cnt >= ctl.pre);
  assign in_act   = per_cnt < per.act;
  assign pwm_o    = (live && in_act) ? ctl.act_high : !ctl.act_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (!live) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else begin
      if (div_tick) pre_cnt <= pre_fire ? '0 : pre_cnt + 1'b1;
      if (pre_fire) per_cnt <= (per_cnt >= per.last) ? '0 : per_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_array.sv
module pwm_array
  import pwm_pkg::*;
#(
  parameter int NCH = 9,
  parameter int AW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_tick,
  input  logic           osc_tick,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           reg_wr,
  input  logic           reg_rd,
  output logic [31:0]    reg_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int NPAIR = (NCH + 1) / 2;

  pair_cfg_t [NPAIR-1:0] pair_cfg;
  chan_ctl_t [NCH-1:0]   ctl_q;
  chan_per_t [NCH-1:0]   per_q;
  logic [NCH-1:0]        gate_q;
  logic [NCH-1:0]        run_q;
  logic [NPAIR-1:0]      pair_tick;

  pwm_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .wr_en(reg_wr), .rd_en(reg_rd), .rdata(reg_rdata),
    .pair_cfg(pair_cfg), .ctl(ctl_q), .per(per_q),
    .gate(gate_q), .run_en(run_q)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_div
    pwm_pair_div u_div (
      .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .osc_tick(osc_tick),
      .cfg(pair_cfg[p]), .div_tick(pair_tick[p])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_chan u_ch (
      .clk(clk), .rst_n(rst_n), .div_tick(pair_tick[c/2]),
      .gate(gate_q[c]), .run_en(run_q[c]), .ctl(ctl_q[c]), .per(per_q[c]),
      .pwm_o(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_array_chk.sv
module pwm_array_chk
  import pwm_pkg::*;
#(
  parameter int NCH = 9,
  parameter int AW  = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [AW-1:0]       reg_addr,
  input logic [31:0]         reg_wdata,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [31:0]         reg_rdata,
  input logic [NCH-1:0]      pwm_out,
  input logic [NCH-1:0]      gate_q,
  input logic [NCH-1:0]      run_q,
  input chan_ctl_t [NCH-1:0] ctl_q,
  input chan_per_t [NCH-1:0] per_q
);
  localparam int NPAIR = (NCH + 1) / 2;

  function automatic logic mapped(input logic [AW-1:0] a);
    logic m;
    m = (a == AW'(GATE_OFS)) || (a == AW'(RUN_OFS));
    for (int p = 0; p < NPAIR; p++) m = m || (a == AW'(CLK_BASE + 4 * p));
    for (int c = 0; c < NCH; c++)
      m = m || (a == AW'(CHAN_BASE + CHAN_STRIDE * c))
            || (a == AW'(CHAN_BASE + CHAN_STRIDE * c + PERIOD_OFS));
    return m;
  endfunction

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !mapped(reg_addr) |=> reg_rdata == 32'd0);

  assert_run_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == AW'(RUN_OFS) |=> run_q == $past(reg_wdata[NCH-1:0]));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_q[c] && run_q[c]) |-> pwm_out[c] == !ctl_q[c].act_high);

    assert_zero_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q[c] && run_q[c] && per_q[c].act == 16'd0) |-> pwm_out[c] == !ctl_q[c].act_high);

    assert_full_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q[c] && run_q[c] && per_q[c].act > per_q[c].last) |-> pwm_out[c] == ctl_q[c].act_high);

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q[c] && run_q[c]) && per_q[c].act != 16'd0 |-> pwm_out[c] == ctl_q[c].act_high);
  end
endmodule

bind pwm_array pwm_array_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pwm_out(pwm_out),
  .gate_q(gate_q), .run_q(run_q), .ctl_q(ctl_q), .per_q(per_q)
);

// File: tb/sim_pwm_array.sv
`timescale 1ns/1ps
module sim_pwm_array;
  localparam int NCH = 9;
  localparam int AW  = 12;
  localparam int LIM = 20000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_tick = 1'b1;
  logic           osc_tick = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic           reg_wr = 1'b0;
  logic           reg_rd = 1'b0;
  logic [31:0]    reg_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;

  pwm_array #(.NCH(NCH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .osc_tick(osc_tick),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  initial begin : osc_gen
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      osc_tick = (n % 3 == 0);
    end
  end

  function automatic int unit_len(input bit src, input int m, input int k);
    int me = (m > 8) ? 8 : m;
    return (src ? 1 : 3) * (k + 1) * (1 << me);
  endfunction

  function automatic int clk_ofs(input int ch);  return 'h20 + 4 * (ch / 2); endfunction
  function automatic int ctl_ofs(input int ch);  return 'h100 + 'h20 * ch;   endfunction
  function automatic int per_ofs(input int ch);  return 'h104 + 'h20 * ch;   endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic prog(input int ch, input bit src, input int m, input int k,
                      input bit pol, input int p, input int a);
    wr(clk_ofs(ch), {24'b0, src, 3'b0, 4'(m)});
    wr(ctl_ofs(ch), {23'b0, pol, 8'(k)});
    wr(per_ofs(ch), {16'(p), 16'(a)});
    wr('h40, 32'(1) << ch);
    wr('h80, 32'(1) << ch);
  endtask

  task automatic measure(input int ch, input bit pol, output int hi, output int lo, output bit ok);
    int t = 0;
    hi = 0; lo = 0;
    while (pwm_out[ch] == pol && t < LIM) begin @(negedge clk); t++; end
    while (pwm_out[ch] != pol && t < LIM) begin @(negedge clk); t++; end
    while (pwm_out[ch] == pol && t < LIM) begin @(negedge clk); t++; hi++; end
    while (pwm_out[ch] != pol && t < LIM) begin @(negedge clk); t++; lo++; end
    ok = (t < LIM);
  endtask

  task automatic steady(input int ch, input int n, output int changes);
    logic v = pwm_out[ch];
    changes = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch] != v) changes++;
    end
  endtask

  task automatic check_wave(input string req, input int ch, input bit src, input int m,
                            input int k, input bit pol, input int p, input int a);
    int hi, lo; bit ok;
    measure(ch, pol, hi, lo, ok);
    chk({req, " timeout"}, ok, 1);
    chk({req, " active length"}, hi, a * unit_len(src, m, k));
    chk({req, " period"}, hi + lo, (p + 1) * unit_len(src, m, k));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int chg;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 outputs idle high", pwm_out, {NCH{1'b1}});
    rd('h80, d); chk("R1 run word", d, 0);
    rd(per_ofs(4), d); chk("R1 period word", d, 0);
    rd(clk_ofs(6), d); chk("R1 clock word", d, 0);

    // R2: readback at mapped offsets
    wr(per_ofs(3), 32'h1234_5678); rd(per_ofs(3), d); chk("R2 period readback", d, 32'h1234_5678);
    wr(ctl_ofs(8), 32'h1A5);       rd(ctl_ofs(8), d); chk("R2 control readback", d, 32'h1A5);
    wr(clk_ofs(8), 32'h85);        rd(clk_ofs(8), d); chk("R2 clock readback", d, 32'h85);
    wr('h40, 32'h1FF);             rd('h40, d);       chk("R2 gate readback", d, 32'h1FF);
    wr('h40, 32'h0);

    // R3: unmapped addresses
    rd('h44, d);  chk("R3 unmapped 0x44", d, 0);
    rd('h108, d); chk("R3 unmapped 0x108", d, 0);
    rd('h104 + 'h20 * NCH, d); chk("R3 beyond last channel", d, 0);

    // R9: run set but gate clear
    wr(ctl_ofs(0), 32'h100); wr(per_ofs(0), {16'd3, 16'd2});
    wr('h80, 32'h1);
    steady(0, 60, chg); chk("R9 gated output stable", chg, 0);
    chk("R9 gated output inactive", pwm_out[0], 0);
    wr('h80, 32'h0); wr('h40, 32'h1);
    steady(0, 60, chg); chk("R9 stopped output inactive", pwm_out[0], 0);

    // R8: constant outputs
    prog(1, 1'b1, 0, 0, 1'b1, 7, 0);
    steady(1, 100, chg); chk("R8 zero active no edges", chg, 0);
    chk("R8 zero active level", pwm_out[1], 0);
    wr(per_ofs(1), {16'd7, 16'd12});
    steady(1, 100, chg); chk("R8 full active no edges", chg, 0);
    chk("R8 full active level", pwm_out[1], 1);

    // R6 / R7: polarity both ways
    prog(2, 1'b1, 0, 1, 1'b1, 5, 2); check_wave("R6 active-high", 2, 1'b1, 0, 1, 1'b1, 5, 2);
    prog(2, 1'b1, 0, 1, 1'b0, 5, 2); check_wave("R6 active-low", 2, 1'b1, 0, 1, 1'b0, 5, 2);

    // R4: pair sharing, channel 3 uses pair word written for channel 2
    wr(ctl_ofs(3), 32'h100); wr(per_ofs(3), {16'd4, 16'd1});
    wr('h40, 32'h8); wr('h80, 32'h8);
    check_wave("R4 shared pair word", 3, 1'b1, 0, 0, 1'b1, 4, 1);
    wr(clk_ofs(2), 32'h02);
    check_wave("R4 shared pair osc div4", 3, 1'b0, 2, 0, 1'b1, 4, 1);

    // R4: exponent clamp
    prog(4, 1'b1, 9, 0, 1'b1, 1, 1);  check_wave("R4 exponent 9 clamps", 4, 1'b1, 9, 0, 1'b1, 1, 1);
    prog(4, 1'b1, 15, 0, 1'b1, 1, 1); check_wave("R4 exponent 15 clamps", 4, 1'b1, 15, 0, 1'b1, 1, 1);

    // R10: restart on enable
    prog(5, 1'b0, 1, 2, 1'b1, 9, 3);
    repeat (37) @(negedge clk);
    wr('h80, 32'h0);
    chk("R10 stop to idle", pwm_out[5], 0);
    wr('h80, 32'h20);
    chk("R10 active right after enable", pwm_out[5], 1);
    check_wave("R10 wave after restart", 5, 1'b0, 1, 2, 1'b1, 9, 3);

    // R11: immediate period update
    prog(6, 1'b1, 0, 0, 1'b1, 1000, 500);
    repeat (10) @(negedge clk);
    chk("R11 long active before write", pwm_out[6], 1);
    wr(per_ofs(6), {16'd3, 16'd2});
    begin
      int t = 0;
      while (pwm_out[6] == 1'b1 && t < 20) begin @(negedge clk); t++; end
      while (pwm_out[6] == 1'b0 && t < 20) begin @(negedge clk); t++; end
      chk("R11 new period reached quickly", (t < 8), 1);
    end
    check_wave("R11 new period shape", 6, 1'b1, 0, 0, 1'b1, 3, 2);

    // R5 / R7: constrained random programs
    for (int it = 0; it < 12; it++) begin
      int ch = $urandom_range(NCH - 1, 0);
      bit src = 1'($urandom_range(1, 0));
      int m = $urandom_range(2, 0);
      int k = $urandom_range(3, 0);
      bit pol = 1'($urandom_range(1, 0));
      int p = $urandom_range(15, 1);
      int a = $urandom_range(p, 1);
      prog(ch, src, m, k, pol, p, a);
      check_wave("R5 R7 random", ch, src, m, k, pol, p, a);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule